// File: doc/BRIEF.md
# Real-Time-Clock Bus Transaction Monitor

This block sits beside an I2C bus that serves a real-time-clock device. It does not sample SCL or SDA itself. An upstream decoder hands it one bus event per cycle: a 3-bit event kind plus the byte that goes with it. The monitor follows the same register-pointer protocol the clock device uses. A write to slave address 0xA2 loads the pointer. Each data byte after that lands in the register the pointer selects, and the pointer then moves on by one. A repeated start followed by address 0xA3 turns the transaction into a read, and the clock's answers are captured in the same way.

The monitor keeps a working copy of the control, time and date registers. When a stop event closes a write or read transaction, it converts the BCD time and date fields to binary. It then presents them for one cycle together with a flag that tells a read from a write. The voltage-low bit and the interrupt-control bits are reported as well. The report outputs keep their values until the next report. Any other event sequence, including traffic to another slave address, sends the sequencer back to idle and produces no report.

Top module: `rtc_bus_monitor`

## Requirements
- R1: While reset is asserted and right after it, `rpt_valid`, `rpt_is_read`, `rpt_vlow`, `rpt_ctrl` and every field output are 0.
- R2: Event kinds are encoded as 0 start, 1 repeated start, 2 address-write, 3 address-read, 4 data-write, 5 data-read, 6 stop and 7 reserved. A start, then an address-write carrying 0xA2, then a data-write loads the register pointer from the low 4 bits of that byte. Every further data-write byte is captured.
- R3: During a write transaction, a repeated start followed by an address-read carrying 0xA3 switches to the read path. There, each data-read byte is captured.
- R4: The pointer increments by one after each captured byte and wraps from 15 to 0. Register 1 is control, 2 seconds, 3 minutes, 4 hours, 5 day, 6 weekday, 7 month and 8 year. Bytes aimed at registers 0 and 9 to 15 change no field. Registers that are not addressed keep their previous contents.
- R5: Each field is reported as low nibble plus ten times high nibble, after a mask: 0x7F for seconds and minutes, 0x3F for hours and day, 0x07 for weekday, 0x1F for month and 0xFF for year.
- R6: Bit 7 of the seconds register is reported on `rpt_vlow` and is excluded from `rpt_sec`.
- R7: `rpt_ctrl` carries bits 4..0 of register 1 in the same bit positions: repeat mode, alarm flag, timer flag, alarm interrupt enable, timer interrupt enable.
- R8: A stop event during a write or read data phase raises `rpt_valid` for exactly one cycle, in the cycle after the stop. `rpt_is_read` is 0 for a write and 1 for a read. The sequencer then returns to idle.
- R9: An address-write byte other than 0xA2, or an address-read byte other than 0xA3, returns the sequencer to idle. No report follows, and later data bytes of that transaction are not captured.
- R10: Any event that does not fit the current state returns the sequencer to idle without a report. A stop in any state other than the two data phases produces no report.
- R11: All report outputs hold their values between reports, even while an aborted transaction changes the working registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 3 | Event kind code |
| ev_byte | input | 8 | Address or data byte of the event |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_is_read | output | 1 | Report came from a read transaction |
| rpt_vlow | output | 1 | Voltage-low flag |
| rpt_ctrl | output | 5 | Interrupt control bits |
| rpt_sec | output | 8 | Seconds, binary |
| rpt_min | output | 8 | Minutes, binary |
| rpt_hour | output | 8 | Hours, binary |
| rpt_day | output | 8 | Day of month, binary |
| rpt_wday | output | 8 | Weekday, binary |
| rpt_month | output | 8 | Month, binary |
| rpt_year | output | 8 | Year, binary |

## Verification
The bench sweeps every tens and units digit of the seconds register, toggling the voltage-low bit and alternating the read and write paths. A wrong mask or a wrong nibble weighting therefore shows up as a bad field value. A design that forgot the voltage-low split would report seconds above 79. Pointer wrap and partial writes are driven so that a pointer that fails to wrap, or a bank that clears untouched registers, leaves the wrong control or seconds value. Wrong slave addresses, misplaced events and early stops target a sequencer that stays in a capture state. Such a design would emit a stray report or pick up bytes that should be dropped, and the held outputs would change without a strobe.

// File: rtl/rtc_mon_pkg.sv
package rtc_mon_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_ADDR_WR = 3'd2,
    EV_ADDR_RD = 3'd3,
    EV_DATA_WR = 3'd4,
    EV_DATA_RD = 3'd5,
    EV_STOP    = 3'd6,
    EV_RSVD    = 3'd7
  } ev_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SLAVE   = 3'd1,
    ST_REGADDR = 3'd2,
    ST_WRITE   = 3'd3,
    ST_RD_ADDR = 3'd4,
    ST_RD_DATA = 3'd5
  } seq_state_t;

  localparam int REG_CTRL  = 1;
  localparam int REG_SEC   = 2;
  localparam int REG_MIN   = 3;
  localparam int REG_HOUR  = 4;
  localparam int REG_DAY   = 5;
  localparam int REG_WDAY  = 6;
  localparam int REG_MONTH = 7;
  localparam int REG_YEAR  = 8;
  localparam int REG_FIRST = REG_CTRL;
  localparam int REG_LAST  = REG_YEAR;

  // Mask applied when a byte is stored into a tracked register.
  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      REG_CTRL:           return 8'h1F;
      REG_SEC:            return 8'hFF; // bit 7 kept for the voltage-low flag
      REG_MIN:            return 8'h7F;
      REG_HOUR, REG_DAY:  return 8'h3F;
      REG_WDAY:           return 8'h07;
      REG_MONTH:          return 8'h1F;
      default:            return 8'hFF;
    endcase
  endfunction

  // Two-digit BCD to binary: low digit plus ten times high digit.
  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    logic [7:0] hi;
    hi = {4'b0, b[7:4]};
    return (hi << 3) + (hi << 1) + {4'b0, b[3:0]};
  endfunction

endpackage

// File: rtl/rtc_mon_seq.sv
module rtc_mon_seq
  import rtc_mon_pkg::*;
#(
  parameter int         PTR_W   = 4,
  parameter logic [7:0] WR_ADDR = 8'hA2,
  parameter logic [7:0] RD_ADDR = 8'hA3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [2:0]       ev_kind,
  input  logic [7:0]       ev_byte,
  output logic             cap_fire,
  output logic [PTR_W-1:0] ptr_q,
  output logic             rpt_fire,
  output logic             rpt_dir_rd,
  output seq_state_t       state_q
);

  ev_kind_t   kind;
  seq_state_t state_d;
  logic       ptr_load;

  assign kind = ev_kind_t'(ev_kind);

  always_comb begin
    state_d    = state_q;
    cap_fire   = 1'b0;
    ptr_load   = 1'b0;
    rpt_fire   = 1'b0;
    rpt_dir_rd = (state_q == ST_RD_DATA);
    if (ev_valid) begin
      case (state_q)
        ST_IDLE:
          state_d = (kind == EV_START) ? ST_SLAVE : ST_IDLE;
        ST_SLAVE:
          state_d = (kind == EV_ADDR_WR && ev_byte == WR_ADDR) ? ST_REGADDR : ST_IDLE;
        ST_REGADDR:
          if (kind == EV_DATA_WR) begin
            state_d  = ST_WRITE;
            ptr_load = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        ST_WRITE:
          case (kind)
            EV_DATA_WR: cap_fire = 1'b1;
            EV_RSTART:  state_d  = ST_RD_ADDR;
            EV_STOP: begin
              rpt_fire = 1'b1;
              state_d  = ST_IDLE;
            end
            default:    state_d  = ST_IDLE;
          endcase
        ST_RD_ADDR:
          state_d = (kind == EV_ADDR_RD && ev_byte == RD_ADDR) ? ST_RD_DATA : ST_IDLE;
        ST_RD_DATA:
          case (kind)
            EV_DATA_RD: cap_fire = 1'b1;
            EV_STOP: begin
              rpt_fire = 1'b1;
              state_d  = ST_IDLE;
            end
            default:    state_d  = ST_IDLE;
          endcase
        default:
          state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ptr_load)
        ptr_q <= ev_byte[PTR_W-1:0];
      else if (cap_fire)
        ptr_q <= ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_mon_regbank.sv
module rtc_mon_regbank
  import rtc_mon_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [PTR_W-1:0]            wr_idx,
  input  logic [7:0]                  wr_byte,
  output logic [REG_LAST:REG_FIRST][7:0] bank
);

  for (genvar g = REG_FIRST; g <= REG_LAST; g++) begin : g_reg
    localparam logic [7:0] MASK = field_mask(g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[g] <= '0;
      else if (wr_en && (32'(wr_idx) == g))
        bank[g] <= wr_byte & MASK;
    end
  end

endmodule

// File: rtl/rtc_mon_report.sv
module rtc_mon_report
  import rtc_mon_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fire,
  input  logic                           dir_rd,
  input  logic [REG_LAST:REG_FIRST][7:0] bank,
  output logic                           rpt_valid,
  output logic                           rpt_is_read,
  output logic                           rpt_vlow,
  output logic [4:0]                     rpt_ctrl,
  output logic [7:0]                     rpt_sec,
  output logic [7:0]                     rpt_min,
  output logic [7:0]                     rpt_hour,
  output logic [7:0]                     rpt_day,
  output logic [7:0]                     rpt_wday,
  output logic [7:0]                     rpt_month,
  output logic [7:0]                     rpt_year
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_valid   <= 1'b0;
      rpt_is_read <= 1'b0;
      rpt_vlow    <= 1'b0;
      rpt_ctrl    <= '0;
      rpt_sec     <= '0;
      rpt_min     <= '0;
      rpt_hour    <= '0;
      rpt_day     <= '0;
      rpt_wday    <= '0;
      rpt_month   <= '0;
      rpt_year    <= '0;
    end else begin
      rpt_valid <= fire;
      if (fire) begin
        rpt_is_read <= dir_rd;
        rpt_vlow    <= bank[REG_SEC][7];
        rpt_ctrl    <= bank[REG_CTRL][4:0];
        rpt_sec     <= bcd_to_bin(bank[REG_SEC] & 8'h7F);
        rpt_min     <= bcd_to_bin(bank[REG_MIN]);
        rpt_hour    <= bcd_to_bin(bank[REG_HOUR]);
        rpt_day     <= bcd_to_bin(bank[REG_DAY]);
        rpt_wday    <= bcd_to_bin(bank[REG_WDAY]);
        rpt_month   <= bcd_to_bin(bank[REG_MONTH]);
        rpt_year    <= bcd_to_bin(bank[REG_YEAR]);
      end
    end
  end

endmodule

// File: rtl/rtc_bus_monitor.sv
module rtc_bus_monitor
  import rtc_mon_pkg::*;
#(
  parameter int         PTR_W   = 4,
  parameter logic [7:0] WR_ADDR = 8'hA2,
  parameter logic [7:0] RD_ADDR = 8'hA3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       rpt_valid,
  output logic       rpt_is_read,
  output logic       rpt_vlow,
  output logic [4:0] rpt_ctrl,
  output logic [7:0] rpt_sec,
  output logic [7:0] rpt_min,
  output logic [7:0] rpt_hour,
  output logic [7:0] rpt_day,
  output logic [7:0] rpt_wday,
  output logic [7:0] rpt_month,
  output logic [7:0] rpt_year
);

  // Named internal events, also observed by the bound checker.
  logic                           cap_fire;
  logic [PTR_W-1:0]               ptr_q;
  logic                           rpt_fire;
  logic                           rpt_dir_rd;
  seq_state_t                     seq_state;
  logic [REG_LAST:REG_FIRST][7:0] bank;

  rtc_mon_seq #(.PTR_W(PTR_W), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .ev_byte    (ev_byte),
    .cap_fire   (cap_fire),
    .ptr_q      (ptr_q),
    .rpt_fire   (rpt_fire),
    .rpt_dir_rd (rpt_dir_rd),
    .state_q    (seq_state)
  );

  rtc_mon_regbank #(.PTR_W(PTR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cap_fire),
    .wr_idx  (ptr_q),
    .wr_byte (ev_byte),
    .bank    (bank)
  );

  rtc_mon_report u_rpt (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (rpt_fire),
    .dir_rd      (rpt_dir_rd),
    .bank        (bank),
    .rpt_valid   (rpt_valid),
    .rpt_is_read (rpt_is_read),
    .rpt_vlow    (rpt_vlow),
    .rpt_ctrl    (rpt_ctrl),
    .rpt_sec     (rpt_sec),
    .rpt_min     (rpt_min),
    .rpt_hour    (rpt_hour),
    .rpt_day     (rpt_day),
    .rpt_wday    (rpt_wday),
    .rpt_month   (rpt_month),
    .rpt_year    (rpt_year)
  );

endmodule

// File: rtl/rtc_bus_monitor_chk.sv
module rtc_bus_monitor_chk
  import rtc_mon_pkg::*;
#(
  parameter int         PTR_W   = 4,
  parameter logic [7:0] WR_ADDR = 8'hA2,
  parameter logic [7:0] RD_ADDR = 8'hA3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic [2:0]       ev_kind,
  input logic [7:0]       ev_byte,
  input logic             cap_fire,
  input logic [PTR_W-1:0] ptr_q,
  input seq_state_t       seq_state,
  input logic             rpt_valid,
  input logic [7:0]       rpt_sec,
  input logic [7:0]       rpt_year,
  input logic [4:0]       rpt_ctrl,
  input logic             rpt_is_read
);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |=> !rpt_valid);

  assert_stop_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> $past(ev_valid && ev_kind == 3'd6));

  assert_bad_wr_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && seq_state == ST_SLAVE && ev_kind == 3'd2 && ev_byte != WR_ADDR)
      |=> (seq_state == ST_IDLE));

  assert_bad_rd_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && seq_state == ST_RD_ADDR && ev_kind == 3'd3 && ev_byte != RD_ADDR)
      |=> (seq_state == ST_IDLE));

  assert_misfit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && seq_state == ST_REGADDR && ev_kind != 3'd4)
      |=> (seq_state == ST_IDLE && !rpt_valid));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_valid |-> ($stable(rpt_sec) && $stable(rpt_year) && $stable(rpt_ctrl)
                    && $stable(rpt_is_read)));

endmodule

bind rtc_bus_monitor rtc_bus_monitor_chk #(.PTR_W(PTR_W), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_valid    (ev_valid),
  .ev_kind     (ev_kind),
  .ev_byte     (ev_byte),
  .cap_fire    (cap_fire),
  .ptr_q       (ptr_q),
  .seq_state   (seq_state),
  .rpt_valid   (rpt_valid),
  .rpt_sec     (rpt_sec),
  .rpt_year    (rpt_year),
  .rpt_ctrl    (rpt_ctrl),
  .rpt_is_read (rpt_is_read)
);

// File: tb/rtc_bus_monitor_test.sv
module rtc_bus_monitor_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'd0;
  logic       rpt_valid, rpt_is_read, rpt_vlow;
  logic [4:0] rpt_ctrl;
  logic [7:0] rpt_sec, rpt_min, rpt_hour, rpt_day, rpt_wday, rpt_month, rpt_year;

  int compared = 0;
  int mismatched = 0;
  int pulses = 0;
  bit done = 0;
  int model [0:15];
  int buff [0:15];

  always #5 clk = ~clk;

  rtc_bus_monitor uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .rpt_valid(rpt_valid), .rpt_is_read(rpt_is_read), .rpt_vlow(rpt_vlow), .rpt_ctrl(rpt_ctrl),
    .rpt_sec(rpt_sec), .rpt_min(rpt_min), .rpt_hour(rpt_hour), .rpt_day(rpt_day),
    .rpt_wday(rpt_wday), .rpt_month(rpt_month), .rpt_year(rpt_year)
  );

  always @(negedge clk) if (rst_n && rpt_valid) pulses++;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dec(input int b, input int mask);
    int v = b & mask;
    return (v % 16) + (v / 16) * 10;
  endfunction

  task automatic ev(input int k, input int b);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_kind  = 3'(k);
    ev_byte  = 8'(b);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // Captured byte: update model register and pointer (R4 map and wrap).
  function automatic int put(input int ptr, input int b);
    if (ptr >= 1 && ptr <= 8) model[ptr] = b;
    return (ptr + 1) % 16;
  endfunction

  task automatic txn(input bit rd, input int sp, input int n);
    int p = sp;
    ev(0, 0); ev(2, 8'hA2); ev(4, sp);
    if (rd) begin ev(1, 0); ev(3, 8'hA3); end
    for (int i = 0; i < n; i++) begin
      ev(rd ? 5 : 4, buff[i]);
      p = put(p, buff[i]);
    end
    ev(6, 0);
  endtask

  task automatic check_report(input bit rd, input int p0);
    @(negedge clk);
    check("R8 pulse count", pulses - p0, 1);
    check("R3/R8 direction", int'(rpt_is_read), int'(rd));
    check("R5 seconds", rpt_sec, dec(model[2], 8'h7F));
    check("R5 minutes", rpt_min, dec(model[3], 8'h7F));
    check("R5 hours", rpt_hour, dec(model[4], 8'h3F));
    check("R5 day", rpt_day, dec(model[5], 8'h3F));
    check("R5 weekday", rpt_wday, dec(model[6], 8'h07));
    check("R5 month", rpt_month, dec(model[7], 8'h1F));
    check("R5 year", rpt_year, dec(model[8], 8'hFF));
    check("R6 voltage low", int'(rpt_vlow), (model[2] >> 7) & 1);
    check("R7 ctrl", int'(rpt_ctrl), model[1] & 8'h1F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int p0;
    int held_sec, held_year, held_ctrl;
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 valid in reset", int'(rpt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", int'(rpt_valid), 0);
    check("R1 dir", int'(rpt_is_read), 0);
    check("R1 seconds", rpt_sec, 0);
    check("R1 year", rpt_year, 0);
    check("R1 ctrl", int'(rpt_ctrl), 0);

    // R2 R3 R5 R6 R7: sweep seconds digits, alternate paths, vary other fields
    for (int t = 0; t < 8; t++) begin
      for (int u = 0; u < 10; u++) begin
        int s = t * 16 + u;
        buff[0] = (s * 7 + 3) & 8'hFF;
        buff[1] = s | (((t + u) & 1) << 7);
        for (int k = 2; k < 8; k++) buff[k] = (s * (k * 37 + 11) + k * 5) & 8'hFF;
        p0 = pulses;
        txn(u[0], 1, 8);
        check_report(u[0], p0);
      end
    end

    // R4: partial write keeps the other registers
    buff[0] = 8'h28; buff[1] = 8'h05;
    p0 = pulses; txn(0, 5, 2); check_report(0, p0);

    // R4: wrap 14,15,0 ignored, then 1 (ctrl) and 2 (seconds)
    buff[0] = 8'h99; buff[1] = 8'h77; buff[2] = 8'h66; buff[3] = 8'h15; buff[4] = 8'hD9;
    p0 = pulses; txn(0, 14, 5); check_report(0, p0);

    // R4: alarm/timer registers only advance the pointer
    buff[0] = 8'h11; buff[1] = 8'h22; buff[2] = 8'h33;
    p0 = pulses; txn(1, 9, 3); check_report(1, p0);

    // R9: wrong write address, later bytes dropped
    p0 = pulses;
    ev(0, 0); ev(2, 8'hA0); ev(4, 2); ev(4, 8'h45); ev(6, 0);
    repeat (2) @(negedge clk);
    check("R9 no report bad write addr", pulses - p0, 0);
    buff[0] = 8'h07;
    p0 = pulses; txn(0, 8, 1); check_report(0, p0);

    // R9: wrong read address, read bytes dropped
    p0 = pulses;
    ev(0, 0); ev(2, 8'hA2); ev(4, 2); ev(1, 0); ev(3, 8'hA5); ev(5, 8'h33); ev(6, 0);
    repeat (2) @(negedge clk);
    check("R9 no report bad read addr", pulses - p0, 0);
    p0 = pulses; txn(0, 8, 0); check_report(0, p0);

    // R10 and R11: misfit after captured bytes; outputs held
    held_sec = rpt_sec; held_year = rpt_year; held_ctrl = rpt_ctrl;
    p0 = pulses;
    ev(0, 0); ev(2, 8'hA2); ev(4, 1); ev(4, 8'h0A);
    model[1] = 8'h0A;
    ev(5, 8'h44); ev(4, 8'h59); ev(6, 0);
    repeat (2) @(negedge clk);
    check("R10 no report after misfit", pulses - p0, 0);
    check("R11 seconds held", rpt_sec, held_sec);
    check("R11 year held", rpt_year, held_year);
    check("R11 ctrl held", int'(rpt_ctrl), held_ctrl);
    // R10: stop while waiting for register address, reserved kind in read wait
    p0 = pulses;
    ev(0, 0); ev(2, 8'hA2); ev(6, 0);
    ev(0, 0); ev(2, 8'hA2); ev(4, 2); ev(1, 0); ev(7, 0); ev(5, 8'h12); ev(6, 0);
    ev(0, 0); ev(6, 0);
    repeat (2) @(negedge clk);
    check("R10 no report on early stops", pulses - p0, 0);
    p0 = pulses; txn(1, 8, 0); check_report(1, p0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule